// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences one DMA channel. A control word selects how the channel is triggered, how much data each beat carries, how many beats make an atomic transfer, how many atomic transfers make a job, and what happens when the job finishes. Once the channel is switched on and a trigger arrives, the block requests the bus. After the grant it issues one beat or a burst of beats. It then drops its bus request for at least one cycle and decrements its current count.

A trigger comes either from a software pulse or from one hardware request line. The hardware line is picked by a select field. In single service each accepted trigger yields one atomic transfer. In whole service one trigger runs atomic transfers back to back until the count is exhausted, and the bus is still given up between them. At terminal count the channel either stays on with the count at zero, so that the next trigger reloads it, or it switches itself off. The address path is reduced to a byte offset that steps by the data size on every beat.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control word is all zero, the channel is off, the current count and byte offset are zero, and no bus request or acknowledge is raised.
- R2: Control bit 24 picks the trigger. When it is 0, a one-cycle pulse on `sw_trig` starts the channel, and the hardware lines and the select field (bits 27:25) have no effect. When it is 1, only `hw_req[sel]` starts the channel, and `sw_trig` and every other line are ignored.
- R3: Each accepted hardware trigger raises `ack_o[sel]` for exactly one cycle, one cycle after the trigger is seen. Software triggers raise no acknowledge.
- R4: Control bit 20 sets the atomic size. With 0 an atomic transfer is one beat. With 1 it is a burst of BURST_LEN beats (4 by default).
- R5: `bus_req` rises on the edge that accepts a trigger. Beats start on the edge after a grant is seen, and no beat is issued while the grant is withheld. After the last beat of every atomic transfer `bus_req` is low for at least one cycle, also in whole service.
- R6: Single service (bit 28 = 0): one trigger produces exactly one atomic transfer, and the channel then waits for another trigger.
- R7: Whole service (bit 28 = 1): one trigger produces atomic transfers until the current count reaches zero, with no further trigger needed.
- R8: The current count falls by one per completed atomic transfer, not per beat. It is loaded from the initial count (bits 19:0) only when a trigger is accepted while it is zero.
- R9: The byte offset clears when the count is loaded and grows by 1, 2 or 4 per beat for data size (bits 22:21) 00, 01 or 10. A whole job therefore covers size × beats-per-atomic × count bytes.
- R10: With reload (bit 23 = 1), reaching zero pulses `tc_o`, keeps the channel on, and the next accepted trigger reloads the initial count.
- R11: Without reload, reaching zero pulses `tc_o` and switches the channel off. Later triggers are then ignored until `chan_en_set` is pulsed.
- R12: A trigger has no effect while the channel is off or while the data size is the reserved value 11. No bus request, no beat and no count change result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Load `ctl_in` into the control register |
| ctl_in | input | CNT_W+SEL_W+6 | Control word |
| chan_en_set | input | 1 | Switch the channel on |
| sw_trig | input | 1 | Software trigger pulse |
| hw_req | input | NSRC | Hardware request lines |
| bus_gnt | input | 1 | Bus grant |
| ack_o | output | NSRC | One-cycle acknowledge per hardware line |
| bus_req | output | 1 | Bus request |
| beat_vld | output | 1 | A data beat occurs this cycle |
| beat_last | output | 1 | Final beat of the atomic transfer |
| byte_ofs | output | CNT_W+$clog2(BURST_LEN)+3 | Byte offset of the next beat |
| cur_cnt | output | CNT_W | Current transfer count |
| chan_on | output | 1 | Channel enabled |
| tc_o | output | 1 | Terminal-count pulse |

## Verification
A software pulse driven high at one falling edge shows up as `bus_req` two falling edges later, because it first passes through the pending latch. A hardware request shows up one falling edge later, together with its acknowledge. With the grant already present, the first beat follows one falling edge after `bus_req`. The bench checks these latencies at exactly those falling edges. For whole jobs, whose length depends on the configuration, it waits a fixed window longer than the slowest job and then compares running totals of beats, bus releases, acknowledges and terminal counts against values computed arithmetically from the control word.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARB  = 2'd1,
      ST_XFER = 2'd2,
      ST_REL  = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      DSZ_BYTE = 2'd0,
      DSZ_HALF = 2'd1,
      DSZ_WORD = 2'd2,
      DSZ_RSVD = 2'd3
   } dsize_e;

   function automatic logic dsize_legal(input logic [1:0] ds);
      return ds != DSZ_RSVD;
   endfunction

endpackage

// File: rtl/dma_req_mux.sv
module dma_req_mux #(
   parameter int NSRC  = 4,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_on,
   input  logic             hw_mode,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             dsize_ok,
   input  logic             sw_trig,
   input  logic [NSRC-1:0]  hw_req,
   input  logic             accept,
   output logic             trig_valid,
   output logic [NSRC-1:0]  ack_o
);

   logic            sw_pend;
   logic [NSRC-1:0] hit_vec;
   logic            hw_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sw_pend <= 1'b0;
      else if (accept || !chan_on || hw_mode)
         sw_pend <= 1'b0;
      else if (sw_trig && dsize_ok)
         sw_pend <= 1'b1;
   end

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      assign hit_vec[gi] = hw_req[gi] && (src_sel == SEL_W'(gi));

      always_ff @(posedge clk) begin
         if (!rst_n)
            ack_o[gi] <= 1'b0;
         else
            ack_o[gi] <= accept && hw_mode && (src_sel == SEL_W'(gi));
      end
   end

   assign hw_hit     = |hit_vec;
   assign trig_valid = chan_on && dsize_ok && (hw_mode ? hw_hit : sw_pend);

   assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o));

   assert_ack_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && hw_mode |=> (ack_o != '0));

   assert_sw_ignored_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_on |=> !sw_pend);

endmodule

// File: rtl/dma_beat_fsm.sv
module dma_beat_fsm
   import dma_seq_pkg::*;
#(
   parameter int BURST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_valid,
   input  logic burst_sel,
   input  logic whole_svc,
   input  logic more_work,
   input  logic bus_gnt,
   output logic accept,
   output logic bus_req,
   output logic beat_vld,
   output logic beat_last
);

   localparam int BC_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   seq_state_e      state, nxt;
   logic [BC_W-1:0] beat_idx;
   logic [BC_W-1:0] last_idx;
   logic            burst_q;

   assign accept    = (state == ST_IDLE) && trig_valid;
   assign bus_req   = (state == ST_ARB) || (state == ST_XFER);
   assign beat_vld  = (state == ST_XFER);
   assign last_idx  = burst_q ? BC_W'(BURST_LEN - 1) : '0;
   assign beat_last = beat_vld && (beat_idx == last_idx);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (trig_valid) nxt = ST_ARB;
         ST_ARB:  if (bus_gnt)    nxt = ST_XFER;
         ST_XFER: if (beat_last)  nxt = ST_REL;
         ST_REL:  nxt = (whole_svc && more_work) ? ST_ARB : ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         beat_idx <= '0;
         burst_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_ARB)
            burst_q <= burst_sel;
         if (state == ST_XFER && !beat_last)
            beat_idx <= beat_idx + 1'b1;
         else
            beat_idx <= '0;
      end
   end

   assert_release_after_atomic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |=> !bus_req);

   assert_no_beat_without_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARB) && !bus_gnt |=> !beat_vld);

   assert_single_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REL) && !whole_svc |=> !bus_req);

endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
   parameter int CNT_W = 20,
   parameter int OFS_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             beat_vld,
   input  logic             atomic_done,
   input  logic [CNT_W-1:0] init_cnt,
   input  logic             reload_en,
   input  logic [1:0]       dsize,
   input  logic             chan_en_set,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             chan_on,
   output logic             tc_o,
   output logic [OFS_W-1:0] byte_ofs
);

   logic             load;
   logic             hit_tc;
   logic [OFS_W-1:0] step;

   assign load   = accept && (cur_cnt == '0);
   assign hit_tc = atomic_done && (cur_cnt == CNT_W'(1));
   assign step   = OFS_W'(1) << dsize;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_cnt  <= '0;
         chan_on  <= 1'b0;
         tc_o     <= 1'b0;
         byte_ofs <= '0;
      end else begin
         tc_o <= hit_tc;

         if (load)
            cur_cnt <= init_cnt;
         else if (atomic_done && cur_cnt != '0)
            cur_cnt <= cur_cnt - 1'b1;

         if (chan_en_set)
            chan_on <= 1'b1;
         else if (hit_tc && !reload_en)
            chan_on <= 1'b0;

         if (load)
            byte_ofs <= '0;
         else if (beat_vld)
            byte_ofs <= byte_ofs + step;
      end
   end

   assert_count_per_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
      beat_vld && !atomic_done |=> $stable(cur_cnt));

   assert_tc_shutoff_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hit_tc && !reload_en && !chan_en_set |=> !chan_on && tc_o);

   assert_tc_reload_keeps_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_tc && reload_en && chan_on |=> chan_on && (cur_cnt == '0));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int CNT_W     = 20,
   parameter int NSRC      = 4,
   parameter int SEL_W     = 3,
   parameter int BURST_LEN = 4,
   localparam int CTL_W    = CNT_W + SEL_W + 6,
   localparam int OFS_W    = CNT_W + $clog2(BURST_LEN) + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_in,
   input  logic             chan_en_set,
   input  logic             sw_trig,
   input  logic [NSRC-1:0]  hw_req,
   input  logic             bus_gnt,
   output logic [NSRC-1:0]  ack_o,
   output logic             bus_req,
   output logic             beat_vld,
   output logic             beat_last,
   output logic [OFS_W-1:0] byte_ofs,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             chan_on,
   output logic             tc_o
);

   localparam int F_BURST = CNT_W;
   localparam int F_DSZ   = CNT_W + 1;
   localparam int F_RELD  = CNT_W + 3;
   localparam int F_HW    = CNT_W + 4;
   localparam int F_SEL   = CNT_W + 5;
   localparam int F_WHOLE = CNT_W + 5 + SEL_W;

   if (BURST_LEN < 2) begin : g_chk_burst
      $error("BURST_LEN must be at least 2");
   end
   if (NSRC < 1 || NSRC > (1 << SEL_W)) begin : g_chk_src
      $error("NSRC must fit the select field");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must be at least 2");
   end

   logic [CTL_W-1:0] ctl_q;
   logic [CNT_W-1:0] f_init;
   logic             f_burst;
   logic [1:0]       f_dsz;
   logic             f_reload;
   logic             f_hw;
   logic [SEL_W-1:0] f_sel;
   logic             f_whole;

   logic trig_valid;
   logic accept;
   logic more_work;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_wr)
         ctl_q <= ctl_in;
   end

   assign f_init   = ctl_q[CNT_W-1:0];
   assign f_burst  = ctl_q[F_BURST];
   assign f_dsz    = ctl_q[F_DSZ +: 2];
   assign f_reload = ctl_q[F_RELD];
   assign f_hw     = ctl_q[F_HW];
   assign f_sel    = ctl_q[F_SEL +: SEL_W];
   assign f_whole  = ctl_q[F_WHOLE];

   assign more_work = chan_on && (cur_cnt != '0);

   dma_req_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_on    (chan_on),
      .hw_mode    (f_hw),
      .src_sel    (f_sel),
      .dsize_ok   (dsize_legal(f_dsz)),
      .sw_trig    (sw_trig),
      .hw_req     (hw_req),
      .accept     (accept),
      .trig_valid (trig_valid),
      .ack_o      (ack_o)
   );

   dma_beat_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_valid (trig_valid),
      .burst_sel  (f_burst),
      .whole_svc  (f_whole),
      .more_work  (more_work),
      .bus_gnt    (bus_gnt),
      .accept     (accept),
      .bus_req    (bus_req),
      .beat_vld   (beat_vld),
      .beat_last  (beat_last)
   );

   dma_cnt_unit #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .beat_vld    (beat_vld),
      .atomic_done (beat_last),
      .init_cnt    (f_init),
      .reload_en   (f_reload),
      .dsize       (f_dsz),
      .chan_en_set (chan_en_set),
      .cur_cnt     (cur_cnt),
      .chan_on     (chan_on),
      .tc_o        (tc_o),
      .byte_ofs    (byte_ofs)
   );

   assert_rsvd_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req && (f_dsz == DSZ_RSVD) && !ctl_wr |=> !bus_req);

endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

   localparam int CNT_W = 20;
   localparam int NSRC  = 4;
   localparam int CTL_W = CNT_W + 3 + 6;
   localparam int OFS_W = CNT_W + 2 + 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ctl_wr = 1'b0;
   logic [CTL_W-1:0] ctl_in = '0;
   logic             chan_en_set = 1'b0;
   logic             sw_trig = 1'b0;
   logic [NSRC-1:0]  hw_req = '0;
   logic             gnt_en = 1'b1;
   logic             bus_gnt;
   logic [NSRC-1:0]  ack_o;
   logic             bus_req, beat_vld, beat_last, chan_on, tc_o;
   logic [OFS_W-1:0] byte_ofs;
   logic [CNT_W-1:0] cur_cnt;

   int checks = 0;
   int fails  = 0;
   int beats_t = 0, rel_t = 0, tc_t = 0;
   int ack_t [NSRC];
   logic prev_req = 1'b0;

   always #2 clk = ~clk;

   assign bus_gnt = bus_req & gnt_en;

   dma_chan_seq i_dma_chan_seq (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_in(ctl_in),
      .chan_en_set(chan_en_set), .sw_trig(sw_trig), .hw_req(hw_req),
      .bus_gnt(bus_gnt), .ack_o(ack_o), .bus_req(bus_req),
      .beat_vld(beat_vld), .beat_last(beat_last), .byte_ofs(byte_ofs),
      .cur_cnt(cur_cnt), .chan_on(chan_on), .tc_o(tc_o)
   );

   initial for (int i = 0; i < NSRC; i++) ack_t[i] = 0;

   always @(negedge clk) begin
      if (beat_vld === 1'b1) beats_t++;
      if (prev_req === 1'b1 && bus_req === 1'b0) rel_t++;
      prev_req = bus_req;
      if (tc_o === 1'b1) tc_t++;
      for (int i = 0; i < NSRC; i++) if (ack_o[i] === 1'b1) ack_t[i]++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [CTL_W-1:0] mk(input int whole, input int sel, input int hw,
                                          input int rel, input int ds, input int b4, input int cnt);
      logic [CTL_W-1:0] r;
      r = '0;
      r[19:0]  = cnt[19:0];
      r[20]    = b4[0];
      r[22:21] = ds[1:0];
      r[23]    = rel[0];
      r[24]    = hw[0];
      r[27:25] = sel[2:0];
      r[28]    = whole[0];
      return r;
   endfunction

   task automatic write_ctl(input logic [CTL_W-1:0] w);
      @(negedge clk); ctl_wr = 1'b1; ctl_in = w;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic turn_on();
      @(negedge clk); chan_en_set = 1'b1;
      @(negedge clk); chan_en_set = 1'b0;
   endtask

   task automatic sw_pulse();
      @(negedge clk); sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
   endtask

   task automatic hw_pulse(input int line);
      @(negedge clk); hw_req[line] = 1'b1;
      @(negedge clk); hw_req = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int b0, r0, t0, a0, a1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(bus_req === 1'b0 && ack_o === '0, "R1 req/ack", int'(bus_req), 0);
      check(chan_on === 1'b0, "R1 chan_on", int'(chan_on), 0);
      check(cur_cnt === '0 && byte_ofs === '0, "R1 count/ofs", int'(cur_cnt), 0);

      // Single service, sw trigger, word, burst, count 3, no reload
      write_ctl(mk(0, 0, 0, 0, 2, 1, 3));
      turn_on();
      b0 = beats_t; r0 = rel_t;
      @(negedge clk); sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0;
      @(negedge clk);
      check(bus_req === 1'b1 && beat_vld === 1'b0, "R5 req latency", int'(bus_req), 1);
      @(negedge clk);
      check(beat_vld === 1'b1, "R5 first beat after grant", int'(beat_vld), 1);
      idle(20);
      check(beats_t - b0 == 4, "R4 burst beats", beats_t - b0, 4);
      check(cur_cnt == 2, "R8 per-atomic decrement", int'(cur_cnt), 2);
      check(rel_t - r0 == 1, "R5 release", rel_t - r0, 1);
      check(int'(byte_ofs) == 16, "R9 word offset", int'(byte_ofs), 16);
      idle(20);
      check(beats_t - b0 == 4, "R6 waits for new trigger", beats_t - b0, 4);
      sw_pulse(); idle(20);
      check(cur_cnt == 1, "R6 second trigger", int'(cur_cnt), 1);
      write_ctl(mk(0, 0, 0, 0, 2, 1, 9));
      t0 = tc_t;
      sw_pulse(); idle(20);
      check(cur_cnt == 0, "R8 no load while nonzero", int'(cur_cnt), 0);
      check(int'(byte_ofs) == 48, "R9 job total", int'(byte_ofs), 48);
      check(tc_t - t0 == 1, "R11 tc pulse", tc_t - t0, 1);
      check(chan_on === 1'b0, "R11 channel off", int'(chan_on), 0);
      b0 = beats_t;
      sw_pulse(); idle(20);
      check(beats_t == b0 && cur_cnt == 0, "R12 trigger while off", beats_t - b0, 0);

      // Whole-service sweep
      for (int ds = 0; ds < 3; ds++)
         for (int b4 = 0; b4 < 2; b4++)
            for (int cnt = 1; cnt <= 3; cnt++)
               for (int rel = 0; rel < 2; rel++) begin
                  int tsz;
                  tsz = b4 ? 4 : 1;
                  write_ctl(mk(1, 0, 0, rel, ds, b4, cnt));
                  turn_on();
                  b0 = beats_t; r0 = rel_t; t0 = tc_t;
                  sw_pulse(); idle(40);
                  check(beats_t - b0 == cnt * tsz, "R7 whole beats", beats_t - b0, cnt * tsz);
                  check(rel_t - r0 == cnt, "R5 release per atomic", rel_t - r0, cnt);
                  check(int'(byte_ofs) == cnt * tsz * (1 << ds), "R9 offset",
                        int'(byte_ofs), cnt * tsz * (1 << ds));
                  check(cur_cnt == 0 && tc_t - t0 == 1, "R7 end count", int'(cur_cnt), 0);
                  check(chan_on === rel[0], "R10 R11 channel state", int'(chan_on), rel);
               end

      // R10 reload: channel still on, next trigger reloads
      b0 = beats_t;
      sw_pulse(); idle(40);
      check(beats_t - b0 == 12, "R10 reload rerun", beats_t - b0, 12);
      check(chan_on === 1'b1, "R10 stays on", int'(chan_on), 1);

      // Hardware mode, line 2
      write_ctl(mk(0, 2, 1, 0, 0, 0, 2));
      turn_on();
      b0 = beats_t; a0 = ack_t[2]; a1 = ack_t[1];
      sw_pulse(); idle(10);
      check(beats_t == b0, "R2 sw ignored in hw mode", beats_t - b0, 0);
      hw_pulse(1); idle(10);
      check(beats_t == b0 && ack_t[1] == a1, "R2 other line ignored", beats_t - b0, 0);
      @(negedge clk); hw_req[2] = 1'b1;
      @(negedge clk); hw_req = '0;
      check(ack_o === 4'b0100 && bus_req === 1'b1, "R3 ack timing", int'(ack_o), 4);
      @(negedge clk);
      check(ack_o === 4'b0000, "R3 ack one cycle", int'(ack_o), 0);
      idle(10);
      check(ack_t[2] - a0 == 1 && beats_t - b0 == 1, "R3 hw transfer", ack_t[2] - a0, 1);
      check(cur_cnt == 1, "R8 hw count", int'(cur_cnt), 1);

      // Software mode: select field and hw lines ignored
      write_ctl(mk(0, 3, 0, 0, 0, 0, 2));
      b0 = beats_t; a0 = ack_t[3];
      hw_pulse(3); idle(10);
      check(beats_t == b0, "R2 hw line ignored in sw mode", beats_t - b0, 0);
      sw_pulse(); idle(10);
      check(beats_t - b0 == 1 && ack_t[3] == a0, "R3 no ack in sw mode", ack_t[3] - a0, 0);

      // Reserved data size
      write_ctl(mk(0, 0, 0, 0, 3, 1, 2));
      turn_on();
      b0 = beats_t; r0 = rel_t;
      sw_pulse(); idle(10);
      check(beats_t == b0 && rel_t == r0 && bus_req === 1'b0, "R12 reserved size", beats_t - b0, 0);
      check(cur_cnt == 0, "R12 count untouched", int'(cur_cnt), 0);

      // Grant withheld
      write_ctl(mk(0, 0, 0, 0, 1, 1, 2));
      gnt_en = 1'b0;
      b0 = beats_t;
      sw_pulse(); idle(10);
      check(bus_req === 1'b1 && beats_t == b0, "R5 wait for grant", beats_t - b0, 0);
      gnt_en = 1'b1;
      idle(20);
      check(beats_t - b0 == 4 && int'(byte_ofs) == 8, "R9 halfword burst", int'(byte_ofs), 8);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule